// File: doc/BRIEF.md
# Register-Mapped I2C Master Controller

This block sits between a CPU and an I2C byte engine. The CPU reads and writes five byte-wide registers over a simple request/ready bus: an own-address register, a clock divider, control, status and data. The divider value is only stored. Accesses to the data register become byte-level bus operations: a start with the address byte, a byte write, a byte read, or a stop. Each operation goes to a bus-side transaction engine over a request/done handshake, and the engine reports ACK or NACK and returns the read byte.

The controller is master-only. The first data write after a start carries the target address, with the direction in bit 0. Later data writes send payload bytes. Each data read returns the byte fetched earlier and fetches the next one. Clearing the enable bit acts as a soft reset. A level interrupt reflects the pending status bit. Any CPU access that needs the engine stalls the CPU bus until the engine finishes.

Top module: `i2c_host_ctl`

## Requirements
- R1: The registers sit at byte offsets 0x00 (own address, write mask 0xFE), 0x04 (divider, mask 0x3F), 0x08 (control, mask 0xFC), 0x0C (status) and 0x10 (data). All reset to 0x00. Any other offset reads 0x00, and a write to it changes nothing.
- R2: Control bit 7 is enable, bit 6 interrupt enable, bit 5 master select, bit 4 transmit direction and bit 2 repeated start. After every control write that is not a soft reset, status bit 5 (busy) equals the written master-select bit.
- R3: A control write with bit 7 at 0, made while enable is 1, is a soft reset. It returns control, status, the divider, the receive byte and the transfer state to reset values, keeps the own-address register, and issues a stop (opcode 3) first if a transfer is open.
- R4: A control write that clears master select while a transfer is open issues a stop (opcode 3) and closes the transfer.
- R5: A control write with master select and repeated start both set, while a transfer is open, issues a stop and closes the transfer. The repeated-start bit then reads back as 0.
- R6: Data writes while enable is 0 start no engine operation and change no register.
- R7: With enable and master select set and no transfer open, a data write issues opcode 0 (start+address) carrying the written byte. On ACK the transfer opens, status bit 0 clears and an interrupt is raised. On NACK status bit 0 sets and no transfer opens.
- R8: With a transfer open, a data write issues opcode 1 (write byte). On ACK status bit 0 clears and an interrupt is raised. On NACK status bit 0 sets, a stop (opcode 3) follows, and the transfer closes.
- R9: In master mode a data read returns the previously latched byte. With a transfer open and transmit direction clear, it issues opcode 2 (read byte), latches the returned byte and raises an interrupt. Otherwise it issues nothing and latches 0xFF.
- R10: Raising an interrupt sets status bit 1 (pending) only when enable and interrupt enable are both 1. The irq output equals status bit 1.
- R11: A status write with bit 1 at 0 clears pending. A status write with bit 4 at 0 clears arbitration-lost. Writing 1 to either bit has no effect.
- R12: An access that needs the engine gets ready only in the cycle the last engine operation completes. The engine request, opcode and byte hold steady until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 5 | Byte offset of the register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready |
| cpu_ready | output | 1 | Access completes at this clock edge |
| eng_req | output | 1 | Engine operation requested |
| eng_op | output | 2 | 0 start+address, 1 write, 2 read, 3 stop |
| eng_byte | output | 8 | Address or data byte for the engine |
| eng_done | input | 1 | Engine completes the current operation |
| eng_ack | input | 1 | ACK received for the operation |
| eng_rbyte | input | 8 | Byte returned by a read operation |
| irq | output | 1 | Level interrupt |

## Verification
A wrong transfer-open flag shows up at the engine port on the next data access: the opcode is 0 where 1 was expected, or the reverse. A wrong flag on a control write shows up as a missing or extra stop. A wrong pending or acknowledge bit shows on irq, or in the next status read, in the cycle after the access completes. A stall that ends early shows as cpu_ready while the engine request is still open, so the bench compares the number of operations logged for each access and the waiting cycles against its own model of each access.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 5;
  localparam int STRIDE = 4;

  localparam int IDX_OADR = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_CTL  = 2;
  localparam int IDX_STS  = 3;
  localparam int IDX_DAT  = 4;

  localparam logic [REG_W-1:0] MASK_OADR = 8'hFE;
  localparam logic [REG_W-1:0] MASK_DIV  = 8'h3F;
  localparam logic [REG_W-1:0] MASK_CTL  = 8'hFC;
  localparam logic [REG_W-1:0] RX_EMPTY  = 8'hFF;

  localparam int C_EN = 7;
  localparam int C_IE = 6;
  localparam int C_MS = 5;
  localparam int C_TX = 4;
  localparam int C_RS = 2;

  localparam int S_BUSY = 5;
  localparam int S_ARB  = 4;
  localparam int S_PEND = 1;
  localparam int S_NACK = 0;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  // value stored by a normal control write; repeated start self-clears
  // when it closes an open transfer in master mode
  function automatic logic [REG_W-1:0] ctl_next(logic [REG_W-1:0] wd, logic xfer_open);
    logic [REG_W-1:0] v;
    v = wd & MASK_CTL;
    if (v[C_MS] && v[C_RS] && xfer_open) v[C_RS] = 1'b0;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] status_pack(logic busy, logic arb, logic pend, logic nack);
    logic [REG_W-1:0] v;
    v = '0;
    v[S_BUSY] = busy;
    v[S_ARB]  = arb;
    v[S_PEND] = pend;
    v[S_NACK] = nack;
    return v;
  endfunction
endpackage

// File: rtl/i2c_host_decode.sv
module i2c_host_decode
  import i2c_host_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]               addr,
  input  logic [NREG-1:0][REG_W-1:0]  regs,
  output logic [NREG-1:0]             sel,
  output logic [REG_W-1:0]            rdata
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i * STRIDE));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rdata = rdata | regs[i];
    end
  end
endmodule

// File: rtl/i2c_host_seq.sv
module i2c_host_seq
  import i2c_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [1:0]       go_op,
  input  logic [REG_W-1:0] go_byte,
  input  logic             go_stop_on_nack,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [REG_W-1:0] eng_byte,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [REG_W-1:0] eng_rbyte,
  output logic             idle,
  output logic             fin,
  output logic             fin_ack,
  output logic [REG_W-1:0] fin_byte
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_MAIN, SQ_TAIL} sq_e;

  sq_e              st_q;
  eng_op_e          op_q;
  logic [REG_W-1:0] byte_q;
  logic             son_q;
  logic             main_nack_tail;

  assign main_nack_tail = (st_q == SQ_MAIN) && eng_done && !eng_ack && son_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      op_q   <= OP_STOP;
      byte_q <= '0;
      son_q  <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (go) begin
          st_q   <= SQ_MAIN;
          op_q   <= eng_op_e'(go_op);
          byte_q <= go_byte;
          son_q  <= go_stop_on_nack;
        end
        SQ_MAIN: if (eng_done) begin
          if (main_nack_tail) begin
            st_q <= SQ_TAIL;
            op_q <= OP_STOP;
          end else begin
            st_q <= SQ_IDLE;
          end
        end
        default: if (eng_done) st_q <= SQ_IDLE;
      endcase
    end
  end

  assign eng_req  = (st_q != SQ_IDLE);
  assign eng_op   = op_q;
  assign eng_byte = byte_q;
  assign idle     = (st_q == SQ_IDLE);
  assign fin      = eng_done && (((st_q == SQ_MAIN) && !main_nack_tail) || (st_q == SQ_TAIL));
  assign fin_ack  = (st_q == SQ_MAIN) && eng_ack;
  assign fin_byte = eng_rbyte;
endmodule

// File: rtl/i2c_host_ctl.sv
module i2c_host_ctl
  import i2c_host_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             cpu_ready,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_byte,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rbyte,
  output logic             irq
);
  logic [REG_W-1:0] oadr_q, div_q, ctl_q, rx_q;
  logic             busy_q, arb_q, pend_q, nack_q, xfer_q;

  logic [NREG-1:0]             sel;
  logic [NREG-1:0][REG_W-1:0]  rd_vec;

  logic en, ie, ms, tx;
  assign en = ctl_q[C_EN];
  assign ie = ctl_q[C_IE];
  assign ms = ctl_q[C_MS];
  assign tx = ctl_q[C_TX];

  // named events
  logic wr_acc, rd_acc;
  logic ev_soft, ev_ctl_stop, ev_dw_op, ev_dr_op, ev_dr_master;
  logic needs_op, seq_go, commit, ev_raise;
  logic [1:0] go_op;

  logic seq_idle, seq_fin, seq_ack;
  logic [REG_W-1:0] seq_rbyte;

  assign wr_acc       = cpu_req && cpu_we;
  assign rd_acc       = cpu_req && !cpu_we;
  assign ev_soft      = wr_acc && sel[IDX_CTL] && en && !cpu_wdata[C_EN];
  assign ev_ctl_stop  = wr_acc && sel[IDX_CTL] && xfer_q &&
                        (ev_soft || !cpu_wdata[C_MS] || cpu_wdata[C_RS]);
  assign ev_dw_op     = wr_acc && sel[IDX_DAT] && en && ms;
  assign ev_dr_master = rd_acc && sel[IDX_DAT] && ms;
  assign ev_dr_op     = ev_dr_master && xfer_q && !tx;
  assign needs_op     = ev_ctl_stop || ev_dw_op || ev_dr_op;

  always_comb begin
    if (ev_ctl_stop)   go_op = OP_STOP;
    else if (ev_dr_op) go_op = OP_READ;
    else if (xfer_q)   go_op = OP_WRITE;
    else               go_op = OP_START;
  end

  assign seq_go    = needs_op && seq_idle;
  assign cpu_ready = cpu_req && (needs_op ? seq_fin : 1'b1);
  assign commit    = cpu_ready;
  assign ev_raise  = commit && en && ie && ((ev_dw_op && seq_ack) || ev_dr_op);

  i2c_host_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .go              (seq_go),
    .go_op           (go_op),
    .go_byte         (cpu_wdata),
    .go_stop_on_nack (ev_dw_op && xfer_q),
    .eng_req         (eng_req),
    .eng_op          (eng_op),
    .eng_byte        (eng_byte),
    .eng_done        (eng_done),
    .eng_ack         (eng_ack),
    .eng_rbyte       (eng_rbyte),
    .idle            (seq_idle),
    .fin             (seq_fin),
    .fin_ack         (seq_ack),
    .fin_byte        (seq_rbyte)
  );

  assign rd_vec[IDX_OADR] = oadr_q;
  assign rd_vec[IDX_DIV]  = div_q;
  assign rd_vec[IDX_CTL]  = ctl_q;
  assign rd_vec[IDX_STS]  = status_pack(busy_q, arb_q, pend_q, nack_q);
  assign rd_vec[IDX_DAT]  = rx_q;

  i2c_host_decode #(.AW(AW)) u_dec (
    .addr  (cpu_addr),
    .regs  (rd_vec),
    .sel   (sel),
    .rdata (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oadr_q <= '0;
      div_q  <= '0;
      ctl_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      arb_q  <= 1'b0;
      pend_q <= 1'b0;
      nack_q <= 1'b0;
      xfer_q <= 1'b0;
    end else if (commit) begin
      if (wr_acc && sel[IDX_OADR]) oadr_q <= cpu_wdata & MASK_OADR;
      if (wr_acc && sel[IDX_DIV])  div_q  <= cpu_wdata & MASK_DIV;

      if (ev_raise) pend_q <= 1'b1;

      if (wr_acc && sel[IDX_STS]) begin
        if (!cpu_wdata[S_PEND]) pend_q <= 1'b0;
        if (!cpu_wdata[S_ARB])  arb_q  <= 1'b0;
      end

      if (ev_dw_op) begin
        nack_q <= !seq_ack;
        if (!xfer_q)      xfer_q <= seq_ack;
        else if (!seq_ack) xfer_q <= 1'b0;
      end

      if (ev_dr_master) rx_q <= ev_dr_op ? seq_rbyte : RX_EMPTY;

      if (wr_acc && sel[IDX_CTL]) begin
        if (ev_soft) begin
          div_q  <= '0;
          ctl_q  <= '0;
          rx_q   <= '0;
          busy_q <= 1'b0;
          arb_q  <= 1'b0;
          pend_q <= 1'b0;
          nack_q <= 1'b0;
          xfer_q <= 1'b0;
        end else begin
          ctl_q  <= ctl_next(cpu_wdata, xfer_q);
          busy_q <= cpu_wdata[C_MS];
          if (!cpu_wdata[C_MS] || cpu_wdata[C_RS]) xfer_q <= 1'b0;
        end
      end
    end
  end

  assign irq = pend_q;
endmodule

// File: rtl/i2c_host_chk.sv
module i2c_host_chk
  import i2c_host_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic [7:0]       cpu_wdata,
  input logic             cpu_ready,
  input logic             eng_req,
  input logic [1:0]       eng_op,
  input logic [7:0]       eng_byte,
  input logic             eng_done,
  input logic             irq,
  input logic [REG_W-1:0] ctl_q,
  input logic [REG_W-1:0] oadr_q,
  input logic             busy_q,
  input logic             pend_q,
  input logic [NREG-1:0]  sel
);
  logic ctl_wr_c, sts_wr_c, soft_c;
  assign ctl_wr_c = cpu_ready && cpu_we && sel[IDX_CTL];
  assign sts_wr_c = cpu_ready && cpu_we && sel[IDX_STS];
  assign soft_c   = ctl_wr_c && ctl_q[C_EN] && !cpu_wdata[C_EN];

  AST_BUSY_TRACKS_MS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_c && !soft_c) |=> (busy_q == $past(cpu_wdata[C_MS]))); // R2

  AST_SOFT_KEEPS_OADR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_c |=> ($stable(oadr_q) && ctl_q == '0 && !pend_q && !busy_q)); // R3

  AST_DISABLED_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && sel[IDX_DAT] && !ctl_q[C_EN]) |-> !eng_req); // R6

  AST_TX_READ_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && sel[IDX_DAT] && ctl_q[C_TX]) |-> !eng_req); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl_q[C_EN] && ctl_q[C_IE])); // R10

  AST_W1_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_c && cpu_wdata[S_PEND] && pend_q) |=> pend_q); // R11

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && eng_req) |-> eng_done); // R12

  AST_ENG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte))); // R12
endmodule

bind i2c_host_ctl i2c_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_wdata (cpu_wdata),
  .cpu_ready (cpu_ready),
  .eng_req   (eng_req),
  .eng_op    (eng_op),
  .eng_byte  (eng_byte),
  .eng_done  (eng_done),
  .irq       (irq),
  .ctl_q     (ctl_q),
  .oadr_q    (oadr_q),
  .busy_q    (busy_q),
  .pend_q    (pend_q),
  .sel       (sel)
);

// File: tb/i2c_host_ctl_bench.sv
module i2c_host_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_ready;
  logic       eng_req;
  logic [1:0] eng_op;
  logic [7:0] eng_byte;
  logic       eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] eng_rbyte = '0;
  logic       irq;

  always #4 clk = ~clk;

  i2c_host_ctl u_i2c_host_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte), .eng_done(eng_done),
    .eng_ack(eng_ack), .eng_rbyte(eng_rbyte), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // engine model
  bit       ack_plan = 1'b1;
  int       lat = 0;
  int       log_n = 0;
  logic [1:0] log_op [4];
  logic [7:0] log_byte [4];
  logic [7:0] last_rb = '0;

  always @(negedge clk) begin
    eng_done <= 1'b0;
    if (eng_req && !eng_done) begin
      if (lat == 0) begin
        logic [7:0] rb;
        rb = 8'($urandom);
        eng_done  <= 1'b1;
        eng_ack   <= (eng_op == 2'd3) ? 1'b1 : ack_plan;
        eng_rbyte <= rb;
        if (eng_op == 2'd2) last_rb = rb;
        if (log_n < 4) begin
          log_op[log_n]   = eng_op;
          log_byte[log_n] = eng_byte;
        end
        log_n++;
        lat = $urandom % 3;
      end else begin
        lat--;
      end
    end
  end

  // reference model
  logic [7:0] m_oadr = 0, m_div = 0, m_ctl = 0, m_rx = 0;
  bit m_busy = 0, m_pend = 0, m_nack = 0, m_xfer = 0;

  function automatic logic [7:0] m_status();
    return {2'b00, m_busy, 1'b0, 2'b00, m_pend, m_nack};
  endfunction

  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_oadr;
      5'h04: return m_div;
      5'h08: return m_ctl;
      5'h0C: return m_status();
      5'h10: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_update(input bit we, input logic [4:0] a, input logic [7:0] d, input bit ack,
                          output int nops, output logic [1:0] op0);
    bit en, ie, ms, tx, raise;
    en = m_ctl[7]; ie = m_ctl[6]; ms = m_ctl[5]; tx = m_ctl[4];
    nops = 0; op0 = 2'd0; raise = 0;
    if (we) begin
      case (a)
        5'h00: m_oadr = d & 8'hFE;
        5'h04: m_div = d & 8'h3F;
        5'h08: begin
          if (en && !d[7]) begin
            if (m_xfer) begin nops = 1; op0 = 2'd3; end
            m_div = 0; m_ctl = 0; m_rx = 0; m_busy = 0; m_pend = 0; m_nack = 0; m_xfer = 0;
          end else begin
            if (m_xfer && (!d[5] || d[2])) begin nops = 1; op0 = 2'd3; end
            m_ctl = d & 8'hFC;
            m_busy = d[5];
            if (!d[5]) m_xfer = 0;
            else if (d[2] && m_xfer) begin m_xfer = 0; m_ctl[2] = 1'b0; end
          end
        end
        5'h0C: begin
          if (!d[1]) m_pend = 0;
        end
        5'h10: if (en && ms) begin
          if (!m_xfer) begin
            nops = 1; op0 = 2'd0;
            if (ack) begin m_xfer = 1; m_nack = 0; raise = 1; end
            else m_nack = 1;
          end else begin
            op0 = 2'd1;
            if (ack) begin nops = 1; m_nack = 0; raise = 1; end
            else begin nops = 2; m_nack = 1; m_xfer = 0; end
          end
        end
        default: ;
      endcase
    end else if (a == 5'h10 && ms) begin
      if (m_xfer && !tx) begin nops = 1; op0 = 2'd2; m_rx = last_rb; raise = 1; end
      else m_rx = 8'hFF;
    end
    if (raise && en && ie) m_pend = 1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  logic [7:0] last_got;

  task automatic acc(input bit we, input logic [4:0] a, input logic [7:0] d, input bit ack,
                     input string tag);
    logic [7:0] exp_rd, got;
    int exp_n, waits;
    logic [1:0] exp_op0;
    exp_rd = m_read(a);
    got = '0;
    ack_plan = ack;
    log_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    forever begin
      #2;
      if (cpu_ready) begin got = cpu_rdata; break; end
      waits++;
      if (waits > 60) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    last_got = got;
    m_update(we, a, d, ack, exp_n, exp_op0);
    chk({tag, " op count"}, log_n, exp_n);
    chk({tag, " R12 stall"}, int'(waits > 0), int'(exp_n > 0));
    if (exp_n > 0 && log_n > 0) chk({tag, " first opcode"}, log_op[0], exp_op0);
    if (exp_n == 2 && log_n > 1) chk({tag, " R8 trailing stop"}, log_op[1], 2'd3);
    if (we && a == 5'h10 && exp_n > 0 && log_n > 0) chk({tag, " op byte"}, log_byte[0], d);
    if (!we) chk({tag, " read data"}, got, exp_rd);
    chk({tag, " R10 irq"}, irq, m_pend);
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [7:0] e, input string tag);
    acc(1'b0, a, 8'h00, 1'b1, tag);
    chk({tag, " literal"}, last_got, e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 190000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and unmapped offsets
    rd_expect(5'h00, 8'h00, "R1 oadr reset");
    rd_expect(5'h04, 8'h00, "R1 div reset");
    rd_expect(5'h08, 8'h00, "R1 ctl reset");
    rd_expect(5'h0C, 8'h00, "R1 sts reset");
    rd_expect(5'h10, 8'h00, "R1 data reset");
    chk("R1 irq reset", irq, 0);
    acc(1'b1, 5'h00, 8'hFF, 1'b1, "R1 oadr mask");
    rd_expect(5'h00, 8'hFE, "R1 oadr mask");
    acc(1'b1, 5'h04, 8'hFF, 1'b1, "R1 div mask");
    rd_expect(5'h04, 8'h3F, "R1 div mask");
    acc(1'b1, 5'h14, 8'hFF, 1'b1, "R1 unmapped write");
    rd_expect(5'h14, 8'h00, "R1 unmapped read");
    rd_expect(5'h01, 8'h00, "R1 unaligned read");

    // R2/R6: master select without enable; data write ignored
    acc(1'b1, 5'h08, 8'h23, 1'b1, "R2 ctl ms only");
    rd_expect(5'h0C, 8'h20, "R2 busy set");
    acc(1'b1, 5'h10, 8'hA0, 1'b1, "R6 disabled write");
    rd_expect(5'h0C, 8'h20, "R6 status unchanged");
    acc(1'b0, 5'h10, 8'h00, 1'b1, "R9 read no address");
    rd_expect(5'h10, 8'hFF, "R9 latched FF");

    // R7/R10/R11
    acc(1'b1, 5'h08, 8'hE0, 1'b1, "R2 enable master");
    acc(1'b1, 5'h10, 8'hA2, 1'b0, "R7 address nack");
    rd_expect(5'h0C, 8'h21, "R7 nack bit");
    acc(1'b1, 5'h10, 8'hA0, 1'b1, "R7 address ack");
    rd_expect(5'h0C, 8'h22, "R7 ack status");
    chk("R10 irq high", irq, 1);
    acc(1'b1, 5'h0C, 8'hFF, 1'b1, "R11 write one");
    chk("R11 pending kept", irq, 1);
    acc(1'b1, 5'h0C, 8'h00, 1'b1, "R11 write zero");
    chk("R11 pending cleared", irq, 0);

    // R8
    acc(1'b1, 5'h10, 8'h5A, 1'b1, "R8 write ack");
    acc(1'b1, 5'h10, 8'h33, 1'b0, "R8 write nack");
    rd_expect(5'h0C, 8'h23, "R8 nack status");
    acc(1'b1, 5'h10, 8'hA1, 1'b1, "R8 restart is address");

    // R9 reads
    acc(1'b0, 5'h10, 8'h00, 1'b1, "R9 read previous");
    acc(1'b0, 5'h10, 8'h00, 1'b1, "R9 read next");
    acc(1'b1, 5'h08, 8'hF0, 1'b1, "R9 set tx");
    acc(1'b0, 5'h10, 8'h00, 1'b1, "R9 read with tx");
    rd_expect(5'h10, 8'hFF, "R9 tx latched FF");

    // R5 repeated start
    acc(1'b1, 5'h08, 8'hE4, 1'b1, "R5 rs with open transfer");
    rd_expect(5'h08, 8'hE0, "R5 rs self-cleared");
    acc(1'b1, 5'h10, 8'hB0, 1'b1, "R5 new address");

    // R4 master clear
    acc(1'b1, 5'h08, 8'hC0, 1'b1, "R4 master clear stop");
    rd_expect(5'h0C, 8'h02, "R4 busy cleared");

    // R10 interrupt gated by ie
    acc(1'b1, 5'h0C, 8'h00, 1'b1, "R10 clear");
    acc(1'b1, 5'h08, 8'hA0, 1'b1, "R10 no ie");
    acc(1'b1, 5'h10, 8'hC4, 1'b1, "R10 ack without ie");
    chk("R10 irq stays low", irq, 0);

    // R3 soft reset with open transfer
    acc(1'b1, 5'h00, 8'h42, 1'b1, "R3 oadr");
    acc(1'b1, 5'h08, 8'h00, 1'b1, "R3 soft reset");
    rd_expect(5'h00, 8'h42, "R3 oadr kept");
    rd_expect(5'h08, 8'h00, "R3 ctl cleared");
    rd_expect(5'h04, 8'h00, "R3 div cleared");

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int k;
      logic [4:0] a;
      logic [7:0] d;
      bit we;
      k = $urandom % 12;
      case (k)
        0: a = 5'h00; 1: a = 5'h04; 2, 3: a = 5'h08; 4: a = 5'h0C;
        5, 6, 7, 8, 9: a = 5'h10; 10: a = 5'h18; default: a = 5'($urandom);
      endcase
      d  = 8'($urandom);
      we = ($urandom % 2) == 0;
      if (a == 5'h08 && ($urandom % 8) != 0) begin d[7] = 1'b1; d[5] = ($urandom % 5) != 0; end
      acc(we, a, d, ($urandom % 4) != 0, "R1-rand R7 R8 R9 mix");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule